// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel. It advances once per pixel-clock enable and drives horizontal sync, vertical sync, a data-enable strobe and the column and row of the current active pixel. It also drives a one-step start-of-frame pulse that an interrupt controller can use as its vblank event. A 24-bit source pixel comes in, and the block packs it onto the panel bus in one of four RGB widths. While data enable is low, the bus is held at zero.

The timing comes from five 32-bit configuration words, applied as plain input vectors. The block copies them into shadow registers only at a frame boundary, so a frame always runs with one consistent set of values. Most count fields are stored minus one. The vertical back porch is the exception: it is stored as the raw line count and may be zero. Each sync output has its own polarity control.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line is (hw+1) active pixels, then (hfp+1) front-porch pixels, then (hsw+1) sync pixels, then (hbp+1) back-porch pixels, counted in pixel-enable steps. The fields are: hsw in cfg_sync[15:0], hfp in cfg_hblank[15:0], hbp in cfg_hblank[31:16], hw in cfg_size[15:0].
- R2: A frame is (vh+1) active lines, then (vfp+1) front-porch lines, then (vsw+1) sync lines, then vbp back-porch lines, where vbp may be 0. The fields are: vsw in cfg_sync[31:16], vfp in cfg_vblank[15:0], vbp in cfg_vblank[31:16], vh in cfg_size[31:16].
- R3: de is high exactly when both the column and the line are in their active parts. x holds the column while the column is active and 0 otherwise. y holds the line index while the line is active and 0 otherwise.
- R4: cfg_ctrl[0] set inverts hsync and cfg_ctrl[1] set inverts vsync, giving active-low pulses. With a bit clear, the sync is high only during its pulse.
- R5: cfg_ctrl[9:8] selects the bus packing: 0=4/4/4, 1=5/6/5, 2=6/6/6, 3=8/8/8 bits. The lanes are red = bits 23:16, green = bits 15:8, blue = bits 7:0. Each lane keeps the top bits of its source colour, and its unused low bits are 0.
- R6: While de is low, rgb_out is 0 whatever pix_in holds.
- R7: sof is raised at the step where the last pixel of the last line wraps to the frame origin. It stays high until the next pixel-enable step and is not raised by reset.
- R8: Configuration is sampled only at the frame wrap. A write in mid-frame has no effect until the next frame. After reset, the first frame runs with all-zero encodings (a 4-pixel line and a 3-line frame).
- R9: While pix_en is low, the counters hold and every timing output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel step per cycle it is high |
| cfg_sync | input | 32 | Horizontal and vertical sync widths, minus one |
| cfg_vblank | input | 32 | Vertical front porch minus one; vertical back porch raw |
| cfg_hblank | input | 32 | Horizontal front and back porch, minus one |
| cfg_size | input | 32 | Active width and height, minus one |
| cfg_ctrl | input | 32 | Sync inversion bits and bus packing mode |
| pix_in | input | 24 | Source pixel, 8 bits per colour |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable |
| x | output | CNT_W | Active column |
| y | output | CNT_W | Active line |
| sof | output | 1 | Start-of-frame pulse |
| rgb_out | output | 24 | Packed panel data |

## Verification
Two things can land in the same pixel step: the frame wrap that loads the shadow registers and raises sof, and a new configuration write. The bench switches the configuration one step before a wrap, so the new words are present when that wrap happens. It then expects the following frame to take on the new geometry, bus packing and polarity at once. Mid-frame writes made in other frames must leave the running frame unchanged. This is judged by the number of pixel steps between sof pulses and by the per-cycle comparison of every output against a behavioural model, with pix_en gapped irregularly throughout.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;
   localparam int WORD_W   = 32;
   localparam int FIELD_W  = 16;
   localparam int HI_LSB   = 16;
   localparam int MODE_LSB = 8;
   localparam int HINV_BIT = 0;
   localparam int VINV_BIT = 1;
   localparam int LANE_W   = 8;
   localparam int LANES    = 3;
   localparam int BUS_W    = LANE_W * LANES;

   // shadow field slots; slot i lives in word i/2, half i%2
   localparam int FLD_HSW = 0;
   localparam int FLD_VSW = 1;
   localparam int FLD_VFP = 2;
   localparam int FLD_VBP = 3;
   localparam int FLD_HFP = 4;
   localparam int FLD_HBP = 5;
   localparam int FLD_WID = 6;
   localparam int FLD_HGT = 7;
   localparam int NUM_FLD = 8;

   typedef enum logic [1:0] {
      BUS_12 = 2'd0,
      BUS_16 = 2'd1,
      BUS_18 = 2'd2,
      BUS_24 = 2'd3
   } bus_fmt_e;

   // lane 0 = blue, 1 = green, 2 = red
   function automatic int lane_bits(bus_fmt_e f, int lane);
      case (f)
         BUS_12:  return 4;
         BUS_16:  return (lane == 1) ? 6 : 5;
         BUS_18:  return 6;
         default: return 8;
      endcase
   endfunction

   function automatic logic [LANE_W-1:0] lane_mask(bus_fmt_e f, int lane);
      logic [LANE_W-1:0] ones;
      ones = '1;
      return ~(ones >> lane_bits(f, lane));
   endfunction
endpackage

// File: rtl/lcdt_cfg_shadow.sv
`timescale 1ns/1ps
module lcdt_cfg_shadow
   import lcdt_pkg::*;
#(
   parameter int CNT_W = 12
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic [WORD_W-1:0]               word_sync,
   input  logic [WORD_W-1:0]               word_vblank,
   input  logic [WORD_W-1:0]               word_hblank,
   input  logic [WORD_W-1:0]               word_size,
   input  logic [WORD_W-1:0]               word_ctrl,
   output logic [NUM_FLD-1:0][CNT_W:0]     fld_len,
   output logic                            hinv,
   output logic                            vinv,
   output bus_fmt_e                        fmt
);
   localparam int LEN_W = CNT_W + 1;

   if (CNT_W < 2 || CNT_W > FIELD_W) begin : g_bad_width
      $error("lcdt_cfg_shadow: CNT_W out of range");
   end

   logic [3:0][WORD_W-1:0]           words;
   logic [NUM_FLD-1:0][CNT_W-1:0]    raw_d;
   logic [NUM_FLD-1:0][CNT_W-1:0]    raw_q;
   logic [3:0]                       ctrl_q;

   assign words = {word_size, word_hblank, word_vblank, word_sync};

   for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
      assign raw_d[i] = words[i/2][(i%2)*HI_LSB +: CNT_W];
      if (i == FLD_VBP) begin : g_raw
         assign fld_len[i] = {1'b0, raw_q[i]};
      end else begin : g_plus1
         assign fld_len[i] = {1'b0, raw_q[i]} + LEN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         ctrl_q <= '0;
      end else if (load) begin
         raw_q  <= raw_d;
         ctrl_q <= {word_ctrl[MODE_LSB+1:MODE_LSB], word_ctrl[VINV_BIT], word_ctrl[HINV_BIT]};
      end
   end

   assign hinv = ctrl_q[0];
   assign vinv = ctrl_q[1];
   assign fmt  = bus_fmt_e'(ctrl_q[3:2]);

   AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable({raw_q, ctrl_q})); // R8
endmodule

// File: rtl/lcdt_axis.sv
`timescale 1ns/1ps
module lcdt_axis #(
   parameter int CNT_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [CNT_W:0]    len_act,
   input  logic [CNT_W:0]    len_fp,
   input  logic [CNT_W:0]    len_sw,
   input  logic [CNT_W:0]    len_bp,
   output logic              last,
   output logic              in_act,
   output logic              in_sync,
   output logic [CNT_W-1:0]  pos
);
   localparam int EDGE_W = CNT_W + 3;

   logic [EDGE_W-1:0] cnt_q;
   logic [EDGE_W-1:0] e_act, e_fp, e_sw, e_tot;

   assign e_act = EDGE_W'(len_act);
   assign e_fp  = e_act + EDGE_W'(len_fp);
   assign e_sw  = e_fp  + EDGE_W'(len_sw);
   assign e_tot = e_sw  + EDGE_W'(len_bp);

   assign last    = (cnt_q + EDGE_W'(1)) >= e_tot;
   assign in_act  = cnt_q < e_act;
   assign in_sync = (cnt_q >= e_fp) && (cnt_q < e_sw);
   assign pos     = in_act ? cnt_q[CNT_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (step)   cnt_q <= last ? '0 : cnt_q + EDGE_W'(1);
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < e_tot); // R1
   AST_SYNC_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync |-> !in_act); // R3
   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/lcdt_pack.sv
`timescale 1ns/1ps
module lcdt_pack
   import lcdt_pkg::*;
(
   input  bus_fmt_e            fmt,
   input  logic                de,
   input  logic [BUS_W-1:0]    pix_in,
   output logic [BUS_W-1:0]    bus_out
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign bus_out[l*LANE_W +: LANE_W] =
         de ? (pix_in[l*LANE_W +: LANE_W] & lane_mask(fmt, l)) : '0;
   end
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
   import lcdt_pkg::*;
#(
   parameter int CNT_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic [31:0]       cfg_sync,
   input  logic [31:0]       cfg_vblank,
   input  logic [31:0]       cfg_hblank,
   input  logic [31:0]       cfg_size,
   input  logic [31:0]       cfg_ctrl,
   input  logic [23:0]       pix_in,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [CNT_W-1:0]  x,
   output logic [CNT_W-1:0]  y,
   output logic              sof,
   output logic [23:0]       rgb_out
);
   if (CNT_W < 2 || CNT_W > FIELD_W) begin : g_bad_width
      $error("lcd_timing_gen: CNT_W out of range");
   end

   logic [NUM_FLD-1:0][CNT_W:0] len;
   logic     hinv, vinv;
   bus_fmt_e fmt;
   logic     h_last, h_act, h_sync;
   logic     v_last, v_act, v_sync;
   logic     frame_wrap;
   logic     sof_q;

   assign frame_wrap = pix_en && h_last && v_last;

   lcdt_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(frame_wrap),
      .word_sync(cfg_sync), .word_vblank(cfg_vblank), .word_hblank(cfg_hblank),
      .word_size(cfg_size), .word_ctrl(cfg_ctrl),
      .fld_len(len), .hinv(hinv), .vinv(vinv), .fmt(fmt)
   );

   lcdt_axis #(.CNT_W(CNT_W)) u_haxis (
      .clk(clk), .rst_n(rst_n), .step(pix_en),
      .len_act(len[FLD_WID]), .len_fp(len[FLD_HFP]),
      .len_sw(len[FLD_HSW]), .len_bp(len[FLD_HBP]),
      .last(h_last), .in_act(h_act), .in_sync(h_sync), .pos(x)
   );

   lcdt_axis #(.CNT_W(CNT_W)) u_vaxis (
      .clk(clk), .rst_n(rst_n), .step(pix_en && h_last),
      .len_act(len[FLD_HGT]), .len_fp(len[FLD_VFP]),
      .len_sw(len[FLD_VSW]), .len_bp(len[FLD_VBP]),
      .last(v_last), .in_act(v_act), .in_sync(v_sync), .pos(y)
   );

   assign de    = h_act && v_act;
   assign hsync = h_sync ^ hinv;
   assign vsync = v_sync ^ vinv;

   lcdt_pack u_pack (.fmt(fmt), .de(de), .pix_in(pix_in), .bus_out(rgb_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sof_q <= 1'b0;
      else if (pix_en) sof_q <= h_last && v_last;
   end
   assign sof = sof_q;

   AST_SOF_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> (de && x == '0 && y == '0)); // R7
   AST_SOF_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && pix_en) |=> !sof); // R7
   AST_DARK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> rgb_out == '0); // R6
   AST_LOW_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == BUS_12) |-> (rgb_out[3:0] == '0 && rgb_out[11:8] == '0 && rgb_out[19:16] == '0)); // R5
endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
   localparam int CW = 12;

   logic clk = 1'b0;
   logic rst_n;
   logic pix_en;
   logic [31:0] cfg_sync, cfg_vblank, cfg_hblank, cfg_size, cfg_ctrl;
   logic [23:0] pix_in;
   logic hsync, vsync, de, sof;
   logic [CW-1:0] x, y;
   logic [23:0] rgb_out;

   always #2.5 clk = ~clk;

   lcd_timing_gen #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
      .cfg_sync(cfg_sync), .cfg_vblank(cfg_vblank), .cfg_hblank(cfg_hblank),
      .cfg_size(cfg_size), .cfg_ctrl(cfg_ctrl), .pix_in(pix_in),
      .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y), .sof(sof), .rgb_out(rgb_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   int m_f[8];
   int m_hinv, m_vinv, m_fmt;
   int hc, vc, msof, pe_count;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int flen(int i);
      return (i == 3) ? m_f[i] : m_f[i] + 1;
   endfunction

   task automatic set_cfg(int ha, int hf, int hs, int hb, int va, int vf, int vs, int vb,
                          int hi, int vi, int fm);
      cfg_sync   = ((vs - 1) << 16) | (hs - 1);
      cfg_vblank = (vb << 16) | (vf - 1);
      cfg_hblank = ((hb - 1) << 16) | (hf - 1);
      cfg_size   = ((va - 1) << 16) | (ha - 1);
      cfg_ctrl   = (fm << 8) | (vi << 1) | hi;
   endtask

   task automatic model_step();
      int htot, vtot;
      htot = flen(6) + flen(4) + flen(0) + flen(5);
      vtot = flen(7) + flen(2) + flen(1) + flen(3);
      pe_count++;
      msof = 0;
      if (hc == htot - 1) begin
         hc = 0;
         if (vc == vtot - 1) begin
            vc = 0;
            msof = 1;
            m_f[0] = cfg_sync[CW-1:0];    m_f[1] = cfg_sync[16 +: CW];
            m_f[2] = cfg_vblank[CW-1:0];  m_f[3] = cfg_vblank[16 +: CW];
            m_f[4] = cfg_hblank[CW-1:0];  m_f[5] = cfg_hblank[16 +: CW];
            m_f[6] = cfg_size[CW-1:0];    m_f[7] = cfg_size[16 +: CW];
            m_hinv = cfg_ctrl[0]; m_vinv = cfg_ctrl[1]; m_fmt = cfg_ctrl[9:8];
         end else vc++;
      end else hc++;
   endtask

   function automatic int lane_w(int fm, int lane);
      case (fm)
         0: return 4;
         1: return (lane == 1) ? 6 : 5;
         2: return 6;
         default: return 8;
      endcase
   endfunction

   task automatic compare();
      int ha, hf, hs, va, vf, vs, e_de, e_hs, e_vs, e_rgb;
      ha = flen(6); hf = flen(4); hs = flen(0);
      va = flen(7); vf = flen(2); vs = flen(1);
      e_de = (hc < ha && vc < va) ? 1 : 0;
      e_hs = ((hc >= ha + hf && hc < ha + hf + hs) ? 1 : 0) ^ m_hinv;
      e_vs = ((vc >= va + vf && vc < va + vf + vs) ? 1 : 0) ^ m_vinv;
      e_rgb = 0;
      if (e_de == 1) begin
         for (int l = 0; l < 3; l++) begin
            int msk;
            msk = (8'hFF << (8 - lane_w(m_fmt, l))) & 8'hFF;
            e_rgb |= ((int'(pix_in) >> (8 * l)) & msk) << (8 * l);
         end
      end
      check("R1/R4 hsync", int'(hsync), e_hs);
      check("R2/R4 vsync", int'(vsync), e_vs);
      check("R3 de", int'(de), e_de);
      check("R3 x", int'(x), (hc < ha) ? hc : 0);
      check("R3 y", int'(y), (vc < va) ? vc : 0);
      check("R5/R6 rgb_out", int'(rgb_out), e_rgb);
      check("R7 sof", int'(sof), msof);
   endtask

   // watchdog
   initial begin
      #750000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      int gaps[6];
      int exp_gaps[6];
      int k, last_sof_pe, prev_sof;
      logic [CW-1:0] px, py;
      logic ph, pv, pd;
      exp_gaps = '{12, 91, 64, 91, 64, 91};
      k = 0; last_sof_pe = 0; prev_sof = 0;
      lfsr = 16'hACE1;
      rst_n = 0; pix_en = 0; pix_in = 24'h0;
      foreach (m_f[i]) m_f[i] = 0;
      m_hinv = 0; m_vinv = 0; m_fmt = 0; hc = 0; vc = 0; msof = 0; pe_count = 0;
      set_cfg(6, 2, 3, 2, 4, 1, 2, 0, 0, 0, 3);   // frame A, sampled at first wrap
      repeat (3) @(negedge clk);
      compare();                                   // R8 reset state (zero encodings)
      rst_n = 1;
      for (int i = 0; i < 2000 && k < 6; i++) begin
         if (pe_count >= 321)      set_cfg(6, 2, 3, 2, 4, 1, 2, 0, 0, 0, 3); // lands on wrap step
         else if (pe_count >= 200) set_cfg(5, 1, 1, 1, 3, 2, 1, 2, 0, 1, 2);
         else if (pe_count >= 130) set_cfg(6, 2, 3, 2, 4, 1, 2, 0, 1, 0, 1);
         else if (pe_count >= 50)  set_cfg(5, 1, 1, 1, 3, 2, 1, 2, 1, 1, 0);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pix_en = (lfsr[1:0] != 2'b00);
         pix_in = {lfsr[7:0], lfsr[15:8], lfsr[11:4]} ^ 24'h5A3C96;
         px = x; py = y; ph = hsync; pv = vsync; pd = de;
         @(posedge clk);
         if (pix_en) model_step();
         @(negedge clk);
         compare();
         if (!pix_en) begin
            check("R9 hold x", int'(x), int'(px));
            check("R9 hold y", int'(y), int'(py));
            check("R9 hold syncs", int'({hsync, vsync, de}), int'({ph, pv, pd}));
         end
         if (sof && !prev_sof) begin
            gaps[k] = pe_count - last_sof_pe;
            last_sof_pe = pe_count;
            k++;
         end
         prev_sof = sof;
      end
      check("R7 sof count", k, 6);
      for (int j = 0; j < 6; j++)
         check("R8 frame length", gaps[j], exp_gaps[j]);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule